// File: doc/BRIEF.md
# Multi-Mode Microcontroller Port

This block is an eight-pin port placed between the bus of an 8-bit microcontroller and a set of external pins. A small mode register picks the role of the pins. They can be general-purpose I/O with a direction register and an output register. They can carry the microcontroller's data bus for a bus that does not multiplex address and data. They can serve as high-order address inputs, captured while an address strobe is high. They can also act as a bidirectional buffer to an external peripheral, gated by two select inputs that are already decoded.

The pins are modelled as separate input, output and per-pin output-enable vectors. The microcontroller data bus is modelled the same way, with one enable for the whole bus. Software writes the mode, direction and output registers through a simple synchronous configuration write port. The current pin levels can be read at any time on a dedicated output.

Top module: `mcu_port_mux`

## Requirements
- R1: After reset the mode register is 0 (GPIO), the direction and output registers are 0, no pin is driven (`pin_oe` = 0) and the data bus is not driven (`bus_oe` = 0).
- R2: In GPIO mode (mode bit 7 = 0, mode[1:0] = 00), `pin_oe` equals the direction register (cfg address 1), pins with a direction bit of 1 drive the output register (cfg address 2), and the data bus is never driven, whatever the strobes and selects are.
- R3: `pin_state` equals `pin_i` in every mode.
- R4: In data port mode (bit 7 = 0, mode[1:0] = 01), `wr_n` low with `rd_n` high drives all eight pins with `bus_i`. `rd_n` low with `wr_n` high drives the data bus with `pin_i`. Otherwise nothing is driven. The GPIO registers have no effect in this mode.
- R5: In address input mode (bit 7 = 0, mode[1:0] = 10) no pin is driven. While `astb` is high, `addr_o` takes `pin_i` at each clock edge. While `astb` is low, `addr_o` holds. In any other mode `addr_o` does not change.
- R6: Latched address bit i comes from pin i, for every i from 0 to 7.
- R7: Mode bit 7 set to 1 selects peripheral mode regardless of mode[1:0].
- R8: In peripheral mode with `psel0` or `psel1` high, the strobes control direction exactly as in R4.
- R9: In peripheral mode with both selects low, neither the pins nor the data bus is driven.
- R10: In data port or peripheral mode, `rd_n` and `wr_n` both low drives neither side.
- R11: The data bus and any pin are never driven in the same cycle.
- R12: Mode[1:0] = 11 with bit 7 = 0 behaves as GPIO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 2 | Register select: 0 mode, 1 direction, 2 output data |
| cfg_wdata | input | 8 | Configuration write data |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| psel0 | input | 1 | Peripheral select 0, already decoded |
| psel1 | input | 1 | Peripheral select 1, already decoded |
| astb | input | 1 | Address strobe, latch transparent while high |
| bus_i | input | 8 | Data driven by the microcontroller |
| bus_o | output | 8 | Data toward the microcontroller |
| bus_oe | output | 1 | Data bus drive enable |
| pin_i | input | 8 | Pin input levels |
| pin_o | output | 8 | Pin output values |
| pin_oe | output | 8 | Per-pin drive enables |
| pin_state | output | 8 | Live pin levels for readback |
| addr_o | output | 8 | Latched high-order address |

## Verification
The assertions assume that the strobes, selects and `astb` are synchronous to `clk` and steady around its rising edge, because the address latch is sampled rather than level-sensitive. The bench changes every input only on the falling edge and samples the combinational outputs one nanosecond later. It sweeps all eight mode encodings against every select and strobe combination. Address capture and hold are checked across whole clock cycles, with the strobe changing only between edges.

// File: rtl/mcu_port_mux.sv
module mcu_port_mux #(
  parameter int W = 8,
  parameter int PERIPH_BIT = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cfg_we,
  input  logic [1:0]   cfg_addr,
  input  logic [W-1:0] cfg_wdata,
  input  logic         rd_n,
  input  logic         wr_n,
  input  logic         psel0,
  input  logic         psel1,
  input  logic         astb,
  input  logic [W-1:0] bus_i,
  output logic [W-1:0] bus_o,
  output logic         bus_oe,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] pin_o,
  output logic [W-1:0] pin_oe,
  output logic [W-1:0] pin_state,
  output logic [W-1:0] addr_o
);
  localparam logic [1:0] M_DATA = 2'b01;
  localparam logic [1:0] M_ADDR = 2'b10;

  logic [W-1:0] mode_q, dir_q, dat_q, addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      dir_q  <= '0;
      dat_q  <= '0;
    end else if (cfg_we) begin
      case (cfg_addr)
        2'd0: mode_q <= cfg_wdata;
        2'd1: dir_q  <= cfg_wdata;
        2'd2: dat_q  <= cfg_wdata;
        default: ;
      endcase
    end
  end

  logic periph, bus_mode, addr_mode, gpio, gate, rd_go, wr_go;

  assign periph    = mode_q[PERIPH_BIT];
  assign bus_mode  = periph | (mode_q[1:0] == M_DATA);
  assign addr_mode = !periph && (mode_q[1:0] == M_ADDR);
  assign gpio      = !bus_mode && !addr_mode;
  assign gate      = periph ? (psel0 | psel1) : 1'b1;
  assign rd_go     = bus_mode & gate & ~rd_n & wr_n;
  assign wr_go     = bus_mode & gate & ~wr_n & rd_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                addr_q <= '0;
    else if (addr_mode && astb) addr_q <= pin_i;
  end

  assign pin_oe    = wr_go ? '1 : (gpio ? dir_q : '0);
  assign pin_o     = wr_go ? bus_i : dat_q;
  assign bus_oe    = rd_go;
  assign bus_o     = pin_i;
  assign pin_state = pin_i;
  assign addr_o    = addr_q;
endmodule

module mcu_port_mux_chk #(
  parameter int W = 8,
  parameter int PERIPH_BIT = 7
) (
  input logic         clk,
  input logic         rst_n,
  input logic         rd_n,
  input logic         wr_n,
  input logic         psel0,
  input logic         psel1,
  input logic         astb,
  input logic         bus_oe,
  input logic [W-1:0] pin_oe,
  input logic [W-1:0] addr_o,
  input logic [W-1:0] mode_q
);
  always @(posedge clk)
    if (!rst_n) p_reset_quiet_r1: assert (pin_oe == '0 && !bus_oe);

  p_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_oe && (pin_oe != '0)));

  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[PERIPH_BIT] && !psel0 && !psel1) |-> (!bus_oe && pin_oe == '0));

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !astb |=> $stable(addr_o));

  p_addr_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_q[PERIPH_BIT] && mode_q[1:0] == 2'b10) |-> pin_oe == '0);

  p_clash_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n && !wr_n) |-> !bus_oe);
endmodule

bind mcu_port_mux mcu_port_mux_chk #(.W(W), .PERIPH_BIT(PERIPH_BIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_n(rd_n), .wr_n(wr_n), .psel0(psel0),
  .psel1(psel1), .astb(astb), .bus_oe(bus_oe), .pin_oe(pin_oe),
  .addr_o(addr_o), .mode_q(mode_q)
);

// File: tb/mcu_port_mux_bench.sv
module mcu_port_mux_bench;
  logic clk = 0, rst_n = 0;
  logic cfg_we = 0;
  logic [1:0] cfg_addr = 0;
  logic [7:0] cfg_wdata = 0;
  logic rd_n = 1, wr_n = 1, psel0 = 0, psel1 = 0, astb = 0;
  logic [7:0] bus_i = 0, pin_i = 0;
  logic [7:0] bus_o, pin_o, pin_oe, pin_state, addr_o;
  logic bus_oe;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  mcu_port_mux u_mcu_port_mux (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .rd_n(rd_n), .wr_n(wr_n), .psel0(psel0),
    .psel1(psel1), .astb(astb), .bus_i(bus_i), .bus_o(bus_o),
    .bus_oe(bus_oe), .pin_i(pin_i), .pin_o(pin_o), .pin_oe(pin_oe),
    .pin_state(pin_state), .addr_o(addr_o)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] dirv, datv;
    #1;
    rd_n = 0; wr_n = 0;
    #10;
    chk("R1", {8'h0, pin_oe}, 16'h0);
    chk("R1", {15'h0, bus_oe}, 16'h0);
    @(negedge clk); rst_n = 1; rd_n = 1; wr_n = 1;
    #1 chk("R1", {addr_o, pin_oe}, 16'h0);

    dirv = 8'h3C; datv = 8'hA6;
    cfg(1, dirv); cfg(2, datv);

    for (int m = 0; m < 8; m++) begin
      logic [7:0] mv;
      mv = {m[2], 5'b0, m[1:0]};
      cfg(0, mv);
      for (int s = 0; s < 4; s++)
        for (int st = 0; st < 4; st++)
          for (int p = 0; p < 3; p++) begin
            logic per, busm, gpio, gate, rgo, wgo;
            logic [7:0] eoe, eo;
            string rq;
            @(negedge clk);
            psel0 = s[0]; psel1 = s[1]; rd_n = st[0]; wr_n = st[1];
            pin_i = (p == 0) ? 8'h5A : (p == 1) ? 8'hC3 : 8'h0F;
            bus_i = ~pin_i ^ 8'h11;
            #1;
            per  = mv[7];
            busm = per || mv[1:0] == 2'b01;
            gpio = !per && (mv[1:0] == 2'b00 || mv[1:0] == 2'b11);
            gate = per ? (s[0] | s[1]) : 1'b1;
            rgo  = busm && gate && !st[0] && st[1];
            wgo  = busm && gate && !st[1] && st[0];
            eoe  = wgo ? 8'hFF : (gpio ? dirv : 8'h00);
            eo   = wgo ? bus_i : datv;
            rq = per ? (gate ? "R7/R8" : "R9") :
                 (mv[1:0] == 2'b01) ? "R4" : (mv[1:0] == 2'b10) ? "R5" :
                 (mv[1:0] == 2'b11) ? "R12" : "R2";
            if (!st[0] && !st[1] && busm) rq = "R10";
            chk(rq, {8'h0, pin_oe}, {8'h0, eoe});
            chk(rq, {8'h0, pin_o & pin_oe}, {8'h0, eo & eoe});
            chk(rq, {7'h0, bus_oe, bus_oe ? bus_o : 8'h0}, {7'h0, rgo, rgo ? pin_i : 8'h0});
            chk("R11", {15'h0, bus_oe && (pin_oe != 0)}, 16'h0);
            chk("R3", {8'h0, pin_state}, {8'h0, pin_i});
          end
    end

    @(negedge clk); rd_n = 1; wr_n = 1; psel0 = 0; psel1 = 0;
    cfg(0, 8'h02);
    @(negedge clk); astb = 1; pin_i = 8'hA5;
    @(negedge clk); chk("R5", {8'h0, addr_o}, 16'h00A5);
    pin_i = 8'h3C;
    @(negedge clk); chk("R5", {8'h0, addr_o}, 16'h003C);
    astb = 0; pin_i = 8'hFF;
    repeat (3) @(negedge clk);
    chk("R5", {8'h0, addr_o}, 16'h003C);
    astb = 1;
    for (int i = 0; i < 8; i++) begin
      pin_i = 8'h1 << i;
      @(negedge clk);
      chk("R6", {8'h0, addr_o}, {8'h0, 8'h1 << i});
    end
    pin_i = 8'h66;
    @(negedge clk); chk("R6", {8'h0, addr_o}, 16'h0066);
    astb = 0;
    cfg(0, 8'h00);
    astb = 1; pin_i = 8'h99;
    repeat (2) @(negedge clk);
    chk("R5", {8'h0, addr_o}, 16'h0066);
    cfg(0, 8'h82);
    repeat (2) @(negedge clk);
    chk("R7", {8'h0, addr_o}, 16'h0066);
    astb = 0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule